// File: doc/BRIEF.md
# VT Path Overhead Byte Generator

This block produces the path overhead byte (V5) of one low-order virtual tributary on the transmit side. It sits in the transmit byte stream of the tributary. A strobe marks the first byte of each VT superframe, and that beat is the V5 slot. The block replaces the slot with a freshly built byte. Every other byte passes through, delayed by one register stage.

The V5 byte carries five fields. BIP-2 is computed over the previous superframe as it left the block. REI, RFI and RDI indications are each chosen by a fixed priority: manual value, then the stored receive copy in ring-protection mode, then automatic generation from receive-side status. The 3-bit signal label is derived from a 4-bit mapping-type setting. Forced AIS overwrites the whole superframe with ones. Tributary loopback sends the received V5 byte unchanged. A two-bit control injects BIP-2 errors, either continuously or under a host bit.

Configuration and status are sampled on the strobe beat only. A change made in the middle of a superframe takes effect at the next boundary.

Top module: `v5_ovh_gen`

## Requirements
- R1: While reset is held, out_vld, out_v5_slot and out_byte are all 0.
- R2: Every valid input beat appears on the outputs one clock later. out_v5_slot marks the beat that was the strobe beat. A non-strobe byte comes out unchanged while AIS is inactive. out_byte holds its value on beats without valid.
- R3: V5 bit 1 (out_byte[7]) is the XOR of bits 7, 5, 3 and 1 of every output byte since the previous strobe beat, or since reset if there was none. V5 bit 2 (out_byte[6]) is the XOR of bits 6, 4, 2 and 0 of the same bytes. This gives even parity, and the previous V5 byte is included in the bytes covered.
- R4: The cfg_err_mode field works as follows:
  - 00 or 11: no error is injected.
  - 01: both BIP-2 bits are inverted.
  - 10: both BIP-2 bits are inverted only when host_err_bit is 1 on the strobe beat.
- R5: The label out_byte[3:1] follows cfg_map_type. Values 0 to 6 give the label equal to the value, and 0 is the unequipped label. Values 7 to 15 give 001.
- R6: REI out_byte[5] is 0 when cfg_rei_en is 0. With cfg_rei_en = 1, REI is st_rei in ring-protection mode (cfg_upsr = 1) and rx_bip_err otherwise.
- R7: RFI out_byte[4] is chosen in this order:
  - cfg_rfi_man_val when cfg_rfi_man_en = 1;
  - otherwise st_rfi when cfg_upsr = 1;
  - otherwise rx_fail OR (ds1_rai AND cfg_map_type = 4, the byte-synchronous mapping).
- R8: RDI out_byte[0] is 0 when cfg_erdi_en = 1. Otherwise it is chosen in this order:
  - cfg_rdi_man_val when cfg_rdi_man_en = 1;
  - otherwise st_rdi when cfg_upsr = 1;
  - otherwise rx_ais OR rx_lop.
- R9: When cfg_lpbk = 1 and AIS is off on the strobe beat, the V5 slot carries lb_v5 unchanged.
- R10: When cfg_ais = 1 on the strobe beat, the V5 slot and every byte until the next strobe are 8'hFF. AIS takes priority over loopback.
- R11: Configuration and status inputs are used only on the strobe beat. A change of cfg_ais between strobes does not alter the bytes of the current superframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input byte valid |
| in_sf_start | input | 1 | First byte of a superframe (V5 slot), qualified by in_vld |
| in_byte | input | 8 | Transmit VT byte stream |
| cfg_ais | input | 1 | Force AIS for the superframe |
| cfg_lpbk | input | 1 | Tributary loopback of V5 |
| cfg_upsr | input | 1 | Ring-protection mode |
| cfg_map_type | input | 4 | Mapping type selecting the signal label |
| cfg_err_mode | input | 2 | BIP-2 error injection mode |
| host_err_bit | input | 1 | Host error trigger for mode 10 |
| cfg_rei_en | input | 1 | REI enable |
| cfg_rfi_man_en | input | 1 | Manual RFI enable |
| cfg_rfi_man_val | input | 1 | Manual RFI value |
| cfg_rdi_man_en | input | 1 | Manual RDI enable |
| cfg_rdi_man_val | input | 1 | Manual RDI value |
| cfg_erdi_en | input | 1 | Enhanced RDI in use; one-bit RDI forced to 0 |
| lb_v5 | input | 8 | Received V5 byte for loopback |
| st_rei | input | 1 | Stored received REI |
| st_rfi | input | 1 | Stored received RFI |
| st_rdi | input | 1 | Stored received RDI |
| rx_bip_err | input | 1 | BIP-2 error seen on the received VT |
| rx_fail | input | 1 | Receive-side failure for automatic RFI |
| rx_ais | input | 1 | Receive-side AIS |
| rx_lop | input | 1 | Receive-side loss of pointer |
| ds1_rai | input | 1 | Incoming DS1 RAI |
| out_vld | output | 1 | Output byte valid |
| out_v5_slot | output | 1 | Output byte is the V5 slot |
| out_byte | output | 8 | Transmit byte with V5 inserted |

## Verification
On a strobe beat the block reads the finished BIP-2 accumulator and restarts it from the V5 byte it has just built. On that same beat it samples every configuration input. The bench changes the configuration and status inputs on every beat, including the strobe beat and the beats around it, and inserts valid gaps right before and after a boundary. A behavioural model samples the inputs only on the strobe beat and keeps its own running parity. Its expected output is compared field by field on every clock, so a parity taken one beat late or a setting picked up between strobes shows up as a mismatch in a named field.

// File: rtl/v5_pkg.sv
package v5_pkg;
  localparam int BYTE_W = 8;
  localparam int BIP_W  = 2;
  localparam int LBL_W  = 3;
  localparam int MAP_W  = 4;

  localparam logic [LBL_W-1:0] LBL_EQUIP     = 3'b001;
  localparam logic [MAP_W-1:0] MAP_BYTE_SYNC = 4'd4;
  localparam logic [MAP_W-1:0] MAP_DIRECT_HI = 4'd6;

  localparam logic [1:0] ERR_CONT = 2'b01;
  localparam logic [1:0] ERR_HOST = 2'b10;

  // bits of a byte that belong to parity lane `lane`
  function automatic logic [BYTE_W-1:0] lane_mask(input int lane);
    logic [BYTE_W-1:0] m;
    m = '0;
    for (int i = 0; i < BYTE_W; i++)
      if ((i % BIP_W) == lane) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [LBL_W-1:0] map_to_label(input logic [MAP_W-1:0] mt);
    if (mt <= MAP_DIRECT_HI) return mt[LBL_W-1:0];
    return LBL_EQUIP;
  endfunction
endpackage

// File: rtl/v5_rst_sync.sv
module v5_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sh_q;
  logic [LAST:0] sh_d;

  always_comb begin
    sh_d = {sh_q[LAST:0], 1'b1} >> 0;
    sh_d = {sh_q, 1'b1} [LAST:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_s = sh_q[LAST];
endmodule

// File: rtl/v5_bip_acc.sv
module v5_bip_acc
  import v5_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              restart,
  input  logic [BYTE_W-1:0] data,
  output logic [BIP_W-1:0]  par_q
);
  logic [BIP_W-1:0] fold;
  logic [BIP_W-1:0] par_d;

  for (genvar l = 0; l < BIP_W; l++) begin : g_lane
    assign fold[l] = ^(data & lane_mask(l));
  end

  always_comb begin
    par_d = par_q;
    if (en) par_d = restart ? fold : (par_q ^ fold);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= '0;
    else        par_q <= par_d;
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(par_q)); // R3
endmodule

// File: rtl/v5_field_sel.sv
module v5_field_sel
  import v5_pkg::*;
(
  input  logic             upsr,
  input  logic [MAP_W-1:0] map_type,
  input  logic             rei_en,
  input  logic             rfi_man_en,
  input  logic             rfi_man_val,
  input  logic             rdi_man_en,
  input  logic             rdi_man_val,
  input  logic             erdi_en,
  input  logic             st_rei,
  input  logic             st_rfi,
  input  logic             st_rdi,
  input  logic             rx_bip_err,
  input  logic             rx_fail,
  input  logic             rx_ais,
  input  logic             rx_lop,
  input  logic             ds1_rai,
  output logic             rei,
  output logic             rfi,
  output logic             rdi,
  output logic [LBL_W-1:0] label
);
  logic byte_sync;
  logic rfi_auto;
  logic rdi_auto;

  assign byte_sync = (map_type == MAP_BYTE_SYNC);
  assign rfi_auto  = rx_fail | (ds1_rai & byte_sync);
  assign rdi_auto  = rx_ais | rx_lop;
  assign label     = map_to_label(map_type);

  always_comb begin
    rei = 1'b0;
    if (rei_en) rei = upsr ? st_rei : rx_bip_err;
  end

  always_comb begin
    if (rfi_man_en) rfi = rfi_man_val;
    else if (upsr)  rfi = st_rfi;
    else            rfi = rfi_auto;
  end

  always_comb begin
    if (erdi_en)         rdi = 1'b0;
    else if (rdi_man_en) rdi = rdi_man_val;
    else if (upsr)       rdi = st_rdi;
    else                 rdi = rdi_auto;
  end
endmodule

// File: rtl/v5_ovh_gen.sv
module v5_ovh_gen
  import v5_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              in_sf_start,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              cfg_ais,
  input  logic              cfg_lpbk,
  input  logic              cfg_upsr,
  input  logic [MAP_W-1:0]  cfg_map_type,
  input  logic [1:0]        cfg_err_mode,
  input  logic              host_err_bit,
  input  logic              cfg_rei_en,
  input  logic              cfg_rfi_man_en,
  input  logic              cfg_rfi_man_val,
  input  logic              cfg_rdi_man_en,
  input  logic              cfg_rdi_man_val,
  input  logic              cfg_erdi_en,
  input  logic [BYTE_W-1:0] lb_v5,
  input  logic              st_rei,
  input  logic              st_rfi,
  input  logic              st_rdi,
  input  logic              rx_bip_err,
  input  logic              rx_fail,
  input  logic              rx_ais,
  input  logic              rx_lop,
  input  logic              ds1_rai,
  output logic              out_vld,
  output logic              out_v5_slot,
  output logic [BYTE_W-1:0] out_byte
);
  logic rst_n_s;

  v5_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  // ---- field selection for the V5 byte
  logic             f_rei, f_rfi, f_rdi;
  logic [LBL_W-1:0] f_label;

  v5_field_sel i_field_sel (
    .upsr        (cfg_upsr),
    .map_type    (cfg_map_type),
    .rei_en      (cfg_rei_en),
    .rfi_man_en  (cfg_rfi_man_en),
    .rfi_man_val (cfg_rfi_man_val),
    .rdi_man_en  (cfg_rdi_man_en),
    .rdi_man_val (cfg_rdi_man_val),
    .erdi_en     (cfg_erdi_en),
    .st_rei      (st_rei),
    .st_rfi      (st_rfi),
    .st_rdi      (st_rdi),
    .rx_bip_err  (rx_bip_err),
    .rx_fail     (rx_fail),
    .rx_ais      (rx_ais),
    .rx_lop      (rx_lop),
    .ds1_rai     (ds1_rai),
    .rei         (f_rei),
    .rfi         (f_rfi),
    .rdi         (f_rdi),
    .label       (f_label)
  );

  // ---- BIP-2 over the outgoing stream
  logic [BIP_W-1:0]  bip_prev;
  logic [BYTE_W-1:0] byte_d;

  v5_bip_acc i_bip_acc (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en      (in_vld),
    .restart (in_sf_start),
    .data    (byte_d),
    .par_q   (bip_prev)
  );

  // ---- next-state logic
  logic              sf_beat;
  logic              ais_q, ais_d, ais_now;
  logic              err_on;
  logic [BIP_W-1:0]  bip_tx;
  logic [BYTE_W-1:0] v5_gen;
  logic              vld_d, slot_d;
  logic [BYTE_W-1:0] out_byte_d;
  logic              vld_q, slot_q;
  logic [BYTE_W-1:0] out_byte_q;

  assign sf_beat = in_vld & in_sf_start;
  assign ais_now = in_sf_start ? cfg_ais : ais_q;

  always_comb begin
    unique case (cfg_err_mode)
      ERR_CONT: err_on = 1'b1;
      ERR_HOST: err_on = host_err_bit;
      default:  err_on = 1'b0;
    endcase
    bip_tx = bip_prev ^ {BIP_W{err_on}};
    v5_gen = {bip_tx, f_rei, f_rfi, f_label, f_rdi};
  end

  always_comb begin
    if (ais_now)          byte_d = '1;
    else if (!in_sf_start) byte_d = in_byte;
    else if (cfg_lpbk)    byte_d = lb_v5;
    else                  byte_d = v5_gen;
  end

  always_comb begin
    ais_d      = sf_beat ? cfg_ais : ais_q;
    vld_d      = in_vld;
    slot_d     = sf_beat;
    out_byte_d = in_vld ? byte_d : out_byte_q;
  end

  // ---- registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ais_q      <= 1'b0;
      vld_q      <= 1'b0;
      slot_q     <= 1'b0;
      out_byte_q <= '0;
    end else begin
      ais_q      <= ais_d;
      vld_q      <= vld_d;
      slot_q     <= slot_d;
      out_byte_q <= out_byte_d;
    end
  end

  assign out_vld     = vld_q;
  assign out_v5_slot = slot_q;
  assign out_byte    = out_byte_q;

  // ---- assertions
  AST_SLOT_HAS_VLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_v5_slot |-> out_vld); // R2
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_vld && !in_sf_start && !ais_q) |=> (out_byte == $past(in_byte))); // R2
  AST_AIS_SLOT_ONES: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sf_beat && cfg_ais) |=> (out_byte == '1)); // R10
  AST_AIS_HELD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_vld && !in_sf_start && ais_q) |=> (out_byte == '1)); // R11
  AST_LPBK_COPY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sf_beat && !cfg_ais && cfg_lpbk) |=> (out_byte == $past(lb_v5))); // R9
  AST_ERDI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sf_beat && !cfg_ais && !cfg_lpbk && cfg_erdi_en) |=> !out_byte[0]); // R8
  AST_UNEQ_LABEL: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sf_beat && !cfg_ais && !cfg_lpbk && cfg_map_type == '0)
      |=> (out_byte[3:1] == '0)); // R5
endmodule

// File: tb/test_v5_ovh_gen.sv
`timescale 1ns/1ps
module test_v5_ovh_gen;
  localparam real HALF   = 2.5;
  localparam int  SF_LEN = 9;
  localparam int  N_SF   = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(HALF) clk = ~clk;

  logic       in_vld = 0, in_sf_start = 0;
  logic [7:0] in_byte = 0, lb_v5 = 0;
  logic       cfg_ais = 0, cfg_lpbk = 0, cfg_upsr = 0;
  logic [3:0] cfg_map_type = 0;
  logic [1:0] cfg_err_mode = 0;
  logic       host_err_bit = 0, cfg_rei_en = 0;
  logic       cfg_rfi_man_en = 0, cfg_rfi_man_val = 0;
  logic       cfg_rdi_man_en = 0, cfg_rdi_man_val = 0, cfg_erdi_en = 0;
  logic       st_rei = 0, st_rfi = 0, st_rdi = 0;
  logic       rx_bip_err = 0, rx_fail = 0, rx_ais = 0, rx_lop = 0, ds1_rai = 0;
  logic       out_vld, out_v5_slot;
  logic [7:0] out_byte;

  v5_ovh_gen i_v5_ovh_gen (.*);

  int n_chk = 0;
  int n_err = 0;
  bit run   = 0;
  bit done  = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  // ---------------- behavioural reference model
  logic       e_vld, e_slot;
  logic [7:0] e_byte;
  int         e_kind;   // 0 payload, 1 generated V5, 2 loopback, 3 AIS slot, 4 AIS held
  bit         e_inj;
  bit [1:0]   m_par;
  bit         m_ais;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld = 0; e_slot = 0; e_byte = 0; e_kind = 0; e_inj = 0;
      m_par = 0; m_ais = 0;
    end else begin
      e_vld  = in_vld;
      e_slot = in_vld && in_sf_start;
      if (in_vld) begin
        bit       ais;
        bit [7:0] b;
        bit [1:0] p;
        ais = in_sf_start ? cfg_ais : m_ais;
        if (ais) begin
          b = 8'hFF; e_kind = in_sf_start ? 3 : 4;
        end else if (!in_sf_start) begin
          b = in_byte; e_kind = 0;
        end else if (cfg_lpbk) begin
          b = lb_v5; e_kind = 2;
        end else begin
          bit inj;
          inj = (cfg_err_mode == 2'b01) || (cfg_err_mode == 2'b10 && host_err_bit);
          e_inj = inj;
          b[7:6] = inj ? ~m_par : m_par;
          b[5] = cfg_rei_en ? (cfg_upsr ? st_rei : rx_bip_err) : 1'b0;
          b[4] = cfg_rfi_man_en ? cfg_rfi_man_val :
                 cfg_upsr ? st_rfi : (rx_fail || (ds1_rai && cfg_map_type == 4));
          b[3:1] = (cfg_map_type <= 6) ? cfg_map_type[2:0] : 3'd1;
          b[0] = cfg_erdi_en ? 1'b0 : cfg_rdi_man_en ? cfg_rdi_man_val :
                 cfg_upsr ? st_rdi : (rx_ais || rx_lop);
          e_kind = 1;
        end
        p = 0;
        for (int i = 0; i < 8; i++) if (b[i]) p[i % 2] = ~p[i % 2];
        m_par = in_sf_start ? p : (m_par ^ p);
        if (in_sf_start) m_ais = cfg_ais;
        e_byte = b;
      end
    end
  end

  // ---------------- compare away from the active edge
  always @(negedge clk) begin
    if (run) begin
      chk("R2 valid", {7'd0, out_vld}, {7'd0, e_vld});
      chk("R2 slot", {7'd0, out_v5_slot}, {7'd0, e_slot});
      case (e_kind)
        1: begin
          chk(e_inj ? "R4 injected BIP-2" : "R3 BIP-2", {6'd0, out_byte[7:6]}, {6'd0, e_byte[7:6]});
          chk("R6 REI", {7'd0, out_byte[5]}, {7'd0, e_byte[5]});
          chk("R7 RFI", {7'd0, out_byte[4]}, {7'd0, e_byte[4]});
          chk("R5 label", {5'd0, out_byte[3:1]}, {5'd0, e_byte[3:1]});
          chk("R8 RDI", {7'd0, out_byte[0]}, {7'd0, e_byte[0]});
        end
        2: chk("R9 loopback", out_byte, e_byte);
        3: chk("R10 AIS slot", out_byte, e_byte);
        4: chk("R11 AIS held", out_byte, e_byte);
        default: chk("R2 payload", out_byte, e_byte);
      endcase
    end
  end

  // ---------------- stimulus
  task automatic shuffle_cfg();
    cfg_ais         = ($urandom_range(0, 7) == 0);
    cfg_lpbk        = ($urandom_range(0, 5) == 0);
    cfg_upsr        = $urandom_range(0, 1);
    cfg_map_type    = $urandom_range(0, 15);
    cfg_err_mode    = $urandom_range(0, 3);
    host_err_bit    = $urandom_range(0, 1);
    cfg_rei_en      = $urandom_range(0, 1);
    cfg_rfi_man_en  = $urandom_range(0, 1);
    cfg_rfi_man_val = $urandom_range(0, 1);
    cfg_rdi_man_en  = $urandom_range(0, 1);
    cfg_rdi_man_val = $urandom_range(0, 1);
    cfg_erdi_en     = ($urandom_range(0, 3) == 0);
    lb_v5           = $urandom_range(0, 255);
    st_rei = $urandom_range(0, 1); st_rfi = $urandom_range(0, 1);
    st_rdi = $urandom_range(0, 1); rx_bip_err = $urandom_range(0, 1);
    rx_fail = $urandom_range(0, 1); rx_ais = $urandom_range(0, 1);
    rx_lop = $urandom_range(0, 1); ds1_rai = $urandom_range(0, 1);
  endtask

  task automatic beat(bit start);
    @(negedge clk);
    while ($urandom_range(0, 4) == 0) begin
      in_vld = 0; shuffle_cfg(); @(negedge clk);
    end
    in_vld = 1; in_sf_start = start; in_byte = $urandom_range(0, 255);
    shuffle_cfg();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", {7'd0, out_vld}, 8'd0);
    chk("R1 reset slot", {7'd0, out_v5_slot}, 8'd0);
    chk("R1 reset byte", out_byte, 8'd0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    run = 1;
    // payload before the first strobe feeds the first BIP-2 (R3)
    for (int k = 0; k < 4; k++) beat(0);
    for (int s = 0; s < N_SF; s++) begin
      for (int k = 0; k < SF_LEN; k++) beat(k == 0);
    end
    @(negedge clk);
    in_vld = 0; in_sf_start = 0;
    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R2 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule